// File: doc/BRIEF.md
# Prescaled SCL Timing Generator

This block turns a fast system clock into the SCL waveform of an I2C master. The clock is first divided by a power of two chosen by a small exponent field, and the divided ticks are then counted through a low phase and a high phase whose lengths come from two count fields. Both count fields hold the wanted number of ticks minus one, so the SCL period is 2^exp × ((high + 1) + (low + 1)) system clocks. Software works out the field values from the target bus rate; the block only counts.

Alongside the SCL level, the block gives the byte engine two single-cycle strobes: one near the middle of each low phase, where SDA may change, and one near the middle of each high phase, where SDA is sampled. The sampled SCL line comes back in so that a target holding SCL low stretches the high phase. Counting resumes only once the line reads high. The width of the count fields is a parameter. The default of 4 bits allows a combined count of up to 32 ticks, and 3 bits allows up to 16.

Top module: `scl_phase_gen`

## Requirements
- R1: During reset and while `en` is low, `scl_out` is 1 (line released) and neither strobe is asserted.
- R2: In the first cycle after `en` is sampled high from the idle state, `scl_out` is 0, so each run opens with a low phase.
- R3: Each low phase lasts exactly (cfg_low + 1) × 2^cfg_exp system clocks, and the same holds for every later low phase.
- R4: With `scl_in` following `scl_out`, each high phase lasts exactly (cfg_high + 1) × 2^cfg_exp system clocks.
- R5: A count field value of 0 gives one prescaled tick, so with both fields 0 the period is 2 × 2^cfg_exp clocks, and this holds up to the largest exponent of 15.
- R6: The prescaler divides by 1 << cfg_exp for every value of the 4-bit exponent.
- R7: While the block is in its high phase and `scl_in` reads 0, counting holds and `scl_out` stays 1. After `scl_in` returns to 1, the high phase still runs its full (cfg_high + 1) × 2^cfg_exp clocks.
- R8: `drive_stb` pulses for exactly one cycle in each low phase, ((cfg_low + 1) >> 1) × 2^cfg_exp clocks after the first low cycle, and only while `scl_out` is 0.
- R9: `sample_stb` pulses for exactly one cycle in each high phase, ((cfg_high + 1) >> 1) × 2^cfg_exp counted clocks after `scl_in` first reads high in that phase. It never pulses while `scl_in` is 0.
- R10: Dropping `en` releases `scl_out` in the next cycle and clears all counts. Raising `en` again starts a complete new low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the generator; low returns it to idle |
| cfg_exp | input | EXP_W | Prescaler exponent, divide by 1 << cfg_exp |
| cfg_high | input | HL_W | High-phase tick count minus one |
| cfg_low | input | HL_W | Low-phase tick count minus one |
| scl_in | input | 1 | Sampled SCL line, low while a target stretches |
| scl_out | output | 1 | SCL level: 0 drive low, 1 release |
| drive_stb | output | 1 | One-cycle strobe in mid low phase for SDA changes |
| sample_stb | output | 1 | One-cycle strobe in mid high phase for SDA sampling |

## Verification
All outputs come straight from registered state, so a change in `en` shows on `scl_out` one clock edge later. A strobe is due in the same cycle in which the prescaler and phase counter reach the midpoint. The bench drives inputs on falling edges and reads outputs on the following falling edge. It counts cycles from the first low cycle after the enabling edge, so phase lengths and strobe offsets come out in whole system clocks and are compared with values worked out from the field formula. For clock stretching, the count restarts in the cycle in which the bench lets `scl_in` go high, and the full high length and the sample offset are expected from that cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;
endpackage

// File: rtl/scl_tick_div.sv
// Power-of-two prescaler: one tick every (1 << exp_sel) running cycles.
module scl_tick_div #(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             tick,
   output logic             at_zero
);
   localparam int PRE_W = (1 << EXP_W) - 1;

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] lim;

   // Thermometer limit: the low exp_sel bits set gives (1 << exp_sel) - 1.
   generate
      for (genvar gi = 0; gi < PRE_W; gi++) begin : g_lim
         assign lim[gi] = (int'(exp_sel) > gi);
      end
   endgenerate

   assign tick    = run && (pcnt == lim);
   assign at_zero = (pcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (clr) begin
         pcnt <= '0;
      end else if (run) begin
         pcnt <= tick ? '0 : pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/scl_phase_ctr.sv
// Low/high phase sequencer counting prescaled ticks.
module scl_phase_ctr
   import scl_gen_pkg::*;
#(
   parameter int HL_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic [HL_W-1:0] high_lim,
   input  logic [HL_W-1:0] low_lim,
   output scl_phase_e      phase,
   output logic [HL_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (!en) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               phase <= PH_LOW;
               cnt   <= '0;
            end
            PH_LOW: begin
               if (tick) begin
                  if (cnt == low_lim) begin
                     phase <= PH_HIGH;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  if (cnt == high_lim) begin
                     phase <= PH_LOW;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/scl_mid_strobe.sv
// Mid-phase strobes: fire when the tick count reaches half the phase length.
module scl_mid_strobe
   import scl_gen_pkg::*;
#(
   parameter int HL_W = 4
) (
   input  logic            run,
   input  logic            at_zero,
   input  scl_phase_e      phase,
   input  logic [HL_W-1:0] cnt,
   input  logic [HL_W-1:0] high_lim,
   input  logic [HL_W-1:0] low_lim,
   output logic            drive_stb,
   output logic            sample_stb
);
   logic [HL_W:0] mid_lo;
   logic [HL_W:0] mid_hi;
   logic [HL_W:0] cnt_x;

   assign mid_lo = ({1'b0, low_lim}  + 1'b1) >> 1;
   assign mid_hi = ({1'b0, high_lim} + 1'b1) >> 1;
   assign cnt_x  = {1'b0, cnt};

   assign drive_stb  = run && at_zero && (phase == PH_LOW)  && (cnt_x == mid_lo);
   assign sample_stb = run && at_zero && (phase == PH_HIGH) && (cnt_x == mid_hi);
endmodule

// File: rtl/scl_phase_gen.sv
// Top: prescaled SCL timing generator with stretch-aware high phase.
module scl_phase_gen
   import scl_gen_pkg::*;
#(
   parameter int HL_W  = 4,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic [HL_W-1:0]  cfg_high,
   input  logic [HL_W-1:0]  cfg_low,
   input  logic             scl_in,
   output logic             scl_out,
   output logic             drive_stb,
   output logic             sample_stb
);
   localparam int MAX_TICKS = 2 * (1 << HL_W);

   generate
      if (HL_W < 1 || HL_W > 4) begin : g_bad_hl
         $error("scl_phase_gen: HL_W must be 1..4, got %0d", HL_W);
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("scl_phase_gen: EXP_W must be 1..5, got %0d", EXP_W);
      end
      if (MAX_TICKS > 32) begin : g_bad_max
         $error("scl_phase_gen: combined count %0d exceeds 32", MAX_TICKS);
      end
   endgenerate

   scl_phase_e      phase;
   logic [HL_W-1:0] cnt;
   logic            tick;
   logic            at_zero;
   logic            run;
   logic            clr;

   // Counting runs through low, and through high only while the line is high.
   assign run = en && ((phase == PH_LOW) || ((phase == PH_HIGH) && scl_in));
   assign clr = !en || (phase == PH_IDLE);

   scl_tick_div #(.EXP_W(EXP_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .clr     (clr),
      .exp_sel (cfg_exp),
      .tick    (tick),
      .at_zero (at_zero)
   );

   scl_phase_ctr #(.HL_W(HL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .tick     (tick),
      .high_lim (cfg_high),
      .low_lim  (cfg_low),
      .phase    (phase),
      .cnt      (cnt)
   );

   scl_mid_strobe #(.HL_W(HL_W)) u_stb (
      .run        (run),
      .at_zero    (at_zero),
      .phase      (phase),
      .cnt        (cnt),
      .high_lim   (cfg_high),
      .low_lim    (cfg_low),
      .drive_stb  (drive_stb),
      .sample_stb (sample_stb)
   );

   assign scl_out = (phase != PH_LOW);
endmodule

// File: rtl/scl_phase_gen_chk.sv
// Property checker bound into every scl_phase_gen instance.
module scl_phase_gen_chk
   import scl_gen_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       scl_in,
   input logic       scl_out,
   input logic       drive_stb,
   input logic       sample_stb,
   input scl_phase_e phase
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (scl_out && !drive_stb && !sample_stb));

   p_low_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_IDLE) |=> !scl_out);

   p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_HIGH && !scl_in) |=> scl_out);

   p_drive_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_stb |-> !scl_out);

   p_drive_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_stb |=> !drive_stb);

   p_sample_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (scl_out && scl_in));

   p_disable_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (scl_out && !drive_stb && !sample_stb));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .scl_in     (scl_in),
   .scl_out    (scl_out),
   .drive_stb  (drive_stb),
   .sample_stb (sample_stb),
   .phase      (phase)
);

// File: tb/scl_phase_gen_test.sv
`timescale 1ns/1ps
module scl_phase_gen_test;
   localparam int NV = 7;
   localparam int LIMIT = 70000;

   // exponent, high field, low field, then expected low, high, drive offset, sample offset
   localparam int V_EXP [NV] = '{0, 0, 2, 1, 3, 5, 15};
   localparam int V_HI  [NV] = '{0, 3, 1, 15, 0, 2, 0};
   localparam int V_LO  [NV] = '{0, 1, 2, 15, 4, 0, 0};
   localparam int E_LO  [NV] = '{1, 2, 12, 32, 40, 32, 32768};
   localparam int E_HI  [NV] = '{1, 4, 8, 32, 8, 96, 32768};
   localparam int E_DO  [NV] = '{0, 1, 4, 16, 16, 0, 0};
   localparam int E_SO  [NV] = '{0, 2, 4, 16, 0, 32, 0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [3:0] cfg_exp = '0;
   logic [3:0] cfg_high = '0;
   logic [3:0] cfg_low = '0;
   logic       stretch = 1'b0;
   logic       scl_in;
   logic       scl_out;
   logic       drive_stb;
   logic       sample_stb;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   assign scl_in = scl_out & ~stretch;

   always #2.5 clk = ~clk;

   scl_phase_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .cfg_exp    (cfg_exp),
      .cfg_high   (cfg_high),
      .cfg_low    (cfg_low),
      .scl_in     (scl_in),
      .scl_out    (scl_out),
      .drive_stb  (drive_stb),
      .sample_stb (sample_stb)
   );

   task automatic chk(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Count low cycles from the current negedge; note drive strobe offset/count.
   task automatic meas_low(output int len, output int off, output int n);
      len = 0; off = -1; n = 0;
      while (scl_out == 1'b0 && len < LIMIT) begin
         if (drive_stb) begin off = len; n++; end
         len++;
         @(negedge clk);
      end
   endtask

   task automatic meas_high(output int len, output int off, output int n);
      len = 0; off = -1; n = 0;
      while (scl_out == 1'b1 && len < LIMIT) begin
         if (sample_stb) begin off = len; n++; end
         len++;
         @(negedge clk);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000 && !done) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
         end
      end
   end

   initial begin
      int lo, hi, lo2, doff, dn, soff, sn, d2, n2, held, spulse;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 scl_out in reset", int'(scl_out), 1);
      chk("R1 strobes in reset", int'(drive_stb | sample_stb), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 scl_out idle with en low", int'(scl_out), 1);

      // Vector walk: R2..R6, R8, R9
      for (int v = 0; v < NV; v++) begin
         cfg_exp  = 4'(V_EXP[v]);
         cfg_high = 4'(V_HI[v]);
         cfg_low  = 4'(V_LO[v]);
         @(negedge clk);
         en = 1'b1;
         @(negedge clk);
         chk($sformatf("R2 low first v%0d", v), int'(scl_out), 0);
         meas_low(lo, doff, dn);
         meas_high(hi, soff, sn);
         meas_low(lo2, d2, n2);
         chk($sformatf("R3 low length v%0d", v), lo, E_LO[v]);
         chk($sformatf("R3 second low length v%0d", v), lo2, E_LO[v]);
         chk($sformatf("R4 high length v%0d", v), hi, E_HI[v]);
         chk($sformatf("R8 drive offset v%0d", v), doff, E_DO[v]);
         chk($sformatf("R8 drive pulses v%0d", v), dn, 1);
         chk($sformatf("R9 sample offset v%0d", v), soff, E_SO[v]);
         chk($sformatf("R9 sample pulses v%0d", v), sn, 1);
         if (v == 0 || v == 6)
            chk($sformatf("R5 zero-field period v%0d", v), lo + hi, 2 * (1 << V_EXP[v]));
         if (v == 6)
            chk("R6 divide by 1<<15", lo, 1 << 15);
         en = 1'b0;
         @(negedge clk);
         chk($sformatf("R10 release after disable v%0d", v), int'(scl_out), 1);
         @(negedge clk);
      end

      // R7/R9: stretch the high phase
      cfg_exp = 4'd1; cfg_high = 4'd1; cfg_low = 4'd0;
      @(negedge clk);
      en = 1'b1;
      stretch = 1'b1;
      @(negedge clk);
      meas_low(lo, doff, dn);
      chk("R7 low before stretch", lo, 2);
      held = 0; spulse = 0;
      for (int k = 0; k < 8; k++) begin
         if (scl_out) held++;
         if (sample_stb) spulse++;
         @(negedge clk);
      end
      chk("R7 scl_out held high while stretched", held, 8);
      chk("R9 no sample strobe while stretched", spulse, 0);
      stretch = 1'b0;
      #0.1;
      meas_high(hi, soff, sn);
      chk("R7 full high after release", hi, 4);
      chk("R9 sample offset after release", soff, 2);
      chk("R9 sample pulses after release", sn, 1);
      en = 1'b0;
      repeat (2) @(negedge clk);

      // R10: disable mid-low, restart with a full low phase
      cfg_exp = 4'd3; cfg_high = 4'd0; cfg_low = 4'd3;
      @(negedge clk);
      en = 1'b1;
      repeat (10) @(negedge clk);
      chk("R10 still low before disable", int'(scl_out), 0);
      en = 1'b0;
      @(negedge clk);
      chk("R10 released one cycle after disable", int'(scl_out), 1);
      chk("R10 strobes off after disable", int'(drive_stb | sample_stb), 0);
      en = 1'b1;
      @(negedge clk);
      meas_low(lo, doff, dn);
      chk("R10 full low after re-enable", lo, 32);
      chk("R8 drive offset after re-enable", doff, 16);
      en = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule